// File: doc/BRIEF.md
# Network Event Statistics Counter Bank

This block keeps six 16-bit event counters for a 10/100 Ethernet MAC and exposes them on a 32-bit register bus. Four counters take one-cycle event pulses straight from the MAC: frames sent without error, frames sent after exactly one collision, frames sent after several collisions, and frames received without error. The remaining two are fed by a small classifier. It looks at the end-of-frame strobe of every received frame, together with the frame's FCS verdict and its length in bits. From these it derives the FCS-error event and the alignment-error event.

Software normally polls a counter with a plain read. That read returns the running total and zeroes the counter in the same access, so each read yields the events seen since the previous one. Every counter also answers at three alias addresses. These let software clear, set or invert chosen bits without a read-modify-write. A plain write at the base address loads a value directly. The bus is a simple single-cycle register port: a request is accepted in the cycle `bus_req` is high, and read data is returned one cycle later with `bus_rvalid`. No back-pressure exists on either side. The event inputs are plain pulses and are never stalled.

Top module: `net_event_counters`

## Requirements
- R1: After reset every counter reads zero.
- R2: Counter index k lives at byte address k*16 (k = 0 tx-ok, 1 single-collision, 2 multi-collision, 3 rx-ok, 4 FCS error, 5 alignment error). A one-cycle event pulse adds exactly one to its counter.
- R3: When `rx_frame_done` is high and `rx_fcs_bad` is high, the FCS counter (k=4) increments. The alignment counter (k=5) increments as well only when `rx_bit_len[2:0]` is non-zero. A frame with a good FCS touches neither counter.
- R4: A read returns the counter in bits 15:0 and zero in bits 31:16, one cycle after the request, with `bus_rvalid` high. Indices 6 and above read as zero.
- R5: A read at the base offset (address bits 3:2 = 0) clears the counter after returning its value, unless `bus_be[1:0]` is 2'b00. A read at offsets 4, 8 or 12 never clears.
- R6: If an event pulse and a clearing read hit the same counter in one cycle, the read returns the old value and the counter holds 1 afterwards.
- R7: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R8: A write at the base offset loads `bus_wdata` bytes 0 and 1, each gated by `bus_be[0]` and `bus_be[1]`; disabled bytes keep their value. A write wins over an event in the same cycle.
- R9: A write at offset 4 clears, at offset 8 sets, and at offset 12 inverts each counter bit whose `bus_wdata` bit is 1 and whose byte is enabled. All other bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_ok | input | 1 | Frame transmitted without error |
| ev_tx_one_coll | input | 1 | Frame transmitted after exactly one collision |
| ev_tx_multi_coll | input | 1 | Frame transmitted after more than one collision |
| ev_rx_ok | input | 1 | Frame received without error |
| rx_frame_done | input | 1 | End of a received frame; qualifies the two inputs below |
| rx_fcs_bad | input | 1 | Received frame failed its FCS check |
| rx_bit_len | input | 14 | Length of the received frame in bits |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: bits 7:4 counter index, bits 3:2 alias |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
Several things are hard to reach from the ports because they must coincide in a single clock edge. These are a clearing read together with an event on the same counter, a write together with an event, and an event arriving while the counter is already at its ceiling. The bench drives the bus request and the event pulse in the same low clock phase to force these collisions. It reaches the ceiling by loading 0xFFFE through a base write and then pulsing past it. Reads with only the upper byte enables set, and reads at alias offsets, are each followed by a full base read. That full read shows at the ports that the earlier read left the counter intact.

// File: rtl/ncnt_pkg.sv
package ncnt_pkg;
  localparam int NUM_CNT  = 6;
  localparam int CNT_W    = 16;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;

  typedef enum logic [1:0] {
    ALIAS_BASE = 2'd0,
    ALIAS_CLR  = 2'd1,
    ALIAS_SET  = 2'd2,
    ALIAS_INV  = 2'd3
  } alias_e;

  typedef enum logic [2:0] {
    WOP_NONE,
    WOP_LOAD,
    WOP_CLR,
    WOP_SET,
    WOP_INV
  } wop_e;
endpackage

// File: rtl/ncnt_classify.sv
module ncnt_classify #(
  parameter int LEN_W = 14
) (
  input  logic             frame_done,
  input  logic             fcs_bad,
  input  logic [LEN_W-1:0] bit_len,
  output logic             fcs_ev,
  output logic             align_ev
);
  // residue of the bit length modulo one byte
  localparam int RES_W = 3;
  logic [RES_W-1:0] residue;

  assign residue  = bit_len[RES_W-1:0];
  assign fcs_ev   = frame_done & fcs_bad;
  assign align_ev = frame_done & fcs_bad & (residue != '0);
endmodule

// File: rtl/ncnt_bus_decode.sv
module ncnt_bus_decode
  import ncnt_pkg::*;
#(
  parameter int NUM    = NUM_CNT,
  parameter int CW     = CNT_W,
  parameter int ADDR_W = 8,
  parameter int BEW    = BE_W
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BEW-1:0]    be,
  input  logic [CW-1:0]     wdata,
  output wop_e              wr_op [NUM],
  output logic [NUM-1:0]    rd_clr,
  output logic [CW-1:0]     wr_mask,
  output logic [CW-1:0]     wr_val,
  output logic              rd_fire,
  output logic              rd_hit,
  output logic [ADDR_W-5:0] rd_idx
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  alias_e           alias_sel;
  logic             in_range;
  logic             low_bytes_on;
  wop_e             op_kind;

  assign idx          = addr[ADDR_W-1:4];
  assign alias_sel    = alias_e'(addr[3:2]);
  assign in_range     = (int'(idx) < NUM);
  assign low_bytes_on = be[0] | be[1];
  assign rd_fire      = req & ~we;
  assign rd_hit       = in_range;
  assign rd_idx       = idx;
  assign wr_val       = wdata;

  // one mask bit per counter bit, taken from the enable of its byte
  for (genvar b = 0; b < CW; b++) begin : g_mask
    assign wr_mask[b] = be[b/8];
  end

  always_comb begin
    unique case (alias_sel)
      ALIAS_BASE: op_kind = WOP_LOAD;
      ALIAS_CLR:  op_kind = WOP_CLR;
      ALIAS_SET:  op_kind = WOP_SET;
      default:    op_kind = WOP_INV;
    endcase
  end

  for (genvar k = 0; k < NUM; k++) begin : g_sel
    logic hit_k;
    assign hit_k     = req & in_range & (int'(idx) == k);
    assign wr_op[k]  = (hit_k & we) ? op_kind : WOP_NONE;
    assign rd_clr[k] = hit_k & ~we & (alias_sel == ALIAS_BASE) & low_bytes_on;
  end
endmodule

// File: rtl/ncnt_counter.sv
module ncnt_counter
  import ncnt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          rd_clr,
  input  wop_e          wr_op,
  input  logic [CW-1:0] wr_mask,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] eff;
  logic [CW-1:0] nxt;

  assign eff = wr_val & wr_mask;

  always_comb begin
    nxt = count;
    unique case (wr_op)
      WOP_LOAD: nxt = (count & ~wr_mask) | eff;
      WOP_CLR:  nxt = count & ~eff;
      WOP_SET:  nxt = count | eff;
      WOP_INV:  nxt = count ^ eff;
      default: begin
        if (rd_clr)                      nxt = inc ? CW'(1) : '0;
        else if (inc && count != CNT_MAX) nxt = count + CW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !rd_clr && wr_op == WOP_NONE && count != CNT_MAX) |=> count == $past(count) + CW'(1));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !rd_clr && wr_op == WOP_NONE && count == CNT_MAX) |=> count == CNT_MAX);

  assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !inc && wr_op == WOP_NONE) |=> count == '0);

  assert_rd_and_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && inc && wr_op == WOP_NONE) |=> count == CW'(1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !rd_clr && wr_op == WOP_NONE) |=> $stable(count));
endmodule

// File: rtl/net_event_counters.sv
module net_event_counters
  import ncnt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_ok,
  input  logic              ev_tx_one_coll,
  input  logic              ev_tx_multi_coll,
  input  logic              ev_rx_ok,
  input  logic              rx_frame_done,
  input  logic              rx_fcs_bad,
  input  logic [LEN_W-1:0]  rx_bit_len,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int IDX_W = ADDR_W - 4;

  logic              fcs_ev, align_ev;
  logic [NUM_CNT-1:0] inc_vec;
  wop_e              wr_op [NUM_CNT];
  logic [NUM_CNT-1:0] rd_clr;
  logic [CNT_W-1:0]  wr_mask, wr_val;
  logic              rd_fire, rd_hit;
  logic [IDX_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  counts [NUM_CNT];
  logic [CNT_W-1:0]  rd_sel;

  ncnt_classify #(.LEN_W(LEN_W)) u_classify (
    .frame_done (rx_frame_done),
    .fcs_bad    (rx_fcs_bad),
    .bit_len    (rx_bit_len),
    .fcs_ev     (fcs_ev),
    .align_ev   (align_ev)
  );

  assign inc_vec = {align_ev, fcs_ev, ev_rx_ok, ev_tx_multi_coll, ev_tx_one_coll, ev_tx_ok};

  ncnt_bus_decode #(.NUM(NUM_CNT), .CW(CNT_W), .ADDR_W(ADDR_W), .BEW(BE_W)) u_decode (
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata[CNT_W-1:0]),
    .wr_op   (wr_op),
    .rd_clr  (rd_clr),
    .wr_mask (wr_mask),
    .wr_val  (wr_val),
    .rd_fire (rd_fire),
    .rd_hit  (rd_hit),
    .rd_idx  (rd_idx)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    ncnt_counter #(.CW(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc_vec[k]),
      .rd_clr  (rd_clr[k]),
      .wr_op   (wr_op[k]),
      .wr_mask (wr_mask),
      .wr_val  (wr_val),
      .count   (counts[k])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (rd_hit && int'(rd_idx) == k) rd_sel = counts[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      if (rd_fire) bus_rdata <= {{(DATA_W-CNT_W){1'b0}}, rd_sel};
    end
  end

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> bus_rdata[DATA_W-1:CNT_W] == '0);

  assert_rvalid_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  assert_align_implies_fcs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_vec[5] |-> (inc_vec[4] && rx_bit_len[2:0] != 3'd0));
endmodule

// File: tb/sim_net_event_counters.sv
module sim_net_event_counters;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_tx_ok = 0, ev_tx_one_coll = 0, ev_tx_multi_coll = 0, ev_rx_ok = 0;
  logic        rx_frame_done = 0, rx_fcs_bad = 0;
  logic [13:0] rx_bit_len = '0;
  logic        bus_req = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_event_counters u0 (.*);

  typedef struct packed {
    logic [2:0]  idx;
    logic [7:0]  npulse;
    logic        dowr;
    logic [1:0]  alias_off;
    logic [3:0]  be;
    logic [15:0] wdata;
    logic [15:0] expv;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd5, 1'b0, 2'd0, 4'h0, 16'h0000, 16'h0005},  // R2 plain count
    '{3'd1, 8'd3, 1'b1, 2'd0, 4'h3, 16'h1234, 16'h1234},  // R8 full load
    '{3'd2, 8'd0, 1'b1, 2'd0, 4'h1, 16'hABCD, 16'h00CD},  // R8 low byte only
    '{3'd3, 8'd2, 1'b1, 2'd2, 4'h3, 16'h0100, 16'h0102},  // R9 set
    '{3'd4, 8'd7, 1'b1, 2'd1, 4'h3, 16'h0003, 16'h0004},  // R9 clear
    '{3'd5, 8'd4, 1'b1, 2'd3, 4'h3, 16'h00FF, 16'h00FB},  // R9 invert, R3
    '{3'd0, 8'd0, 1'b1, 2'd0, 4'h2, 16'h5A77, 16'h5A00},  // R8 high byte only
    '{3'd1, 8'd1, 1'b1, 2'd3, 4'h0, 16'hFFFF, 16'h0001},  // R9 no enables
    '{3'd2, 8'd0, 1'b1, 2'd2, 4'h3, 16'hFFFF, 16'hFFFF},  // R9 set all
    '{3'd3, 8'd9, 1'b1, 2'd1, 4'h2, 16'hFFFF, 16'h0009}   // R9 clear upper byte
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic set_ev(input int idx, input logic v);
    case (idx)
      0: ev_tx_ok = v;
      1: ev_tx_one_coll = v;
      2: ev_tx_multi_coll = v;
      3: ev_rx_ok = v;
      4: begin rx_frame_done = v; rx_fcs_bad = v; rx_bit_len = 14'd512; end
      default: begin rx_frame_done = v; rx_fcs_bad = v; rx_bit_len = 14'd509; end
    endcase
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); set_ev(idx, 1'b1);
      @(negedge clk); set_ev(idx, 1'b0);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_req = 0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all counters zero after reset
    for (int k = 0; k < 6; k++) begin
      bus_read(8'(k*16), 4'hF, rd);
      check($sformatf("R1 reset idx%0d", k), rd, 32'h0);
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      pulse(int'(VECS[v].idx), int'(VECS[v].npulse));
      if (VECS[v].dowr)
        bus_write({1'b0, VECS[v].idx, VECS[v].alias_off, 2'b00}, VECS[v].be, {16'h0, VECS[v].wdata});
      bus_read({1'b0, VECS[v].idx, 4'h0}, 4'h3, rd);
      check($sformatf("R2/R8/R9 vec%0d value", v), rd, {16'h0, VECS[v].expv});
      bus_read({1'b0, VECS[v].idx, 4'h0}, 4'h3, rd);
      check($sformatf("R5 vec%0d cleared", v), rd, 32'h0);
      if (VECS[v].idx == 3'd5) begin
        bus_read(8'h40, 4'h3, rd);
        check("R3 misaligned bad frame also counts FCS", rd, {24'h0, VECS[v].npulse});
      end
    end

    // R3: good FCS with odd length touches nothing; bad FCS aligned counts FCS only
    @(negedge clk); rx_frame_done = 1; rx_fcs_bad = 0; rx_bit_len = 14'd509;
    @(negedge clk); rx_frame_done = 0;
    bus_read(8'h40, 4'h3, rd); check("R3 good fcs no fcs count", rd, 32'h0);
    bus_read(8'h50, 4'h3, rd); check("R3 good fcs no align count", rd, 32'h0);
    pulse(4, 2);
    bus_read(8'h50, 4'h3, rd); check("R3 aligned bad frame no align count", rd, 32'h0);
    bus_read(8'h40, 4'h3, rd); check("R3 aligned bad frame fcs count", rd, 32'h2);

    // R7: saturation
    bus_write(8'h10, 4'h3, 32'h0000_FFFE);
    pulse(1, 3);
    bus_read(8'h10, 4'h3, rd); check("R7 saturate", rd, 32'h0000_FFFF);

    // R5: upper-only enables do not clear; alias read does not clear
    bus_write(8'h20, 4'h3, 32'h0000_0042);
    bus_read(8'h20, 4'hC, rd); check("R5 upper-be read value", rd, 32'h42);
    bus_read(8'h24, 4'hF, rd); check("R5 alias read value", rd, 32'h42);
    bus_read(8'h20, 4'h1, rd); check("R5 counter kept", rd, 32'h42);
    bus_read(8'h20, 4'h1, rd); check("R5 low-byte read clears", rd, 32'h0);

    // R6: event and clearing read in the same cycle
    pulse(0, 4);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 8'h00; bus_be = 4'h3; ev_tx_ok = 1;
    @(negedge clk);
    bus_req = 0; ev_tx_ok = 0;
    check("R6 read returns old value", bus_rdata, 32'h4);
    bus_read(8'h00, 4'h3, rd); check("R6 event kept", rd, 32'h1);

    // R8: write wins over event
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 8'h30; bus_be = 4'h3; bus_wdata = 32'h10; ev_rx_ok = 1;
    @(negedge clk);
    bus_req = 0; bus_we = 0; ev_rx_ok = 0;
    bus_read(8'h30, 4'h3, rd); check("R8 write priority", rd, 32'h10);

    // R4: upper half reads zero; out-of-range index reads zero
    bus_write(8'h30, 4'hF, 32'hFFFF_1234);
    bus_read(8'h30, 4'hF, rd); check("R4 upper zero", rd, 32'h0000_1234);
    bus_write(8'h60, 4'hF, 32'h0000_7777);
    bus_read(8'h60, 4'hF, rd); check("R4 out of range", rd, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule